// File: doc/BRIEF.md
# Hardware/Software Selectable Clock Gate Controller

This block computes the enable for one gated clock. An owner select bit decides who controls the gate: in hardware mode the enable follows a hardware request line, in software mode it follows a software enable bit. A status bit reports the gate state two cycles after the enable changes. This models the settling time of the downstream gating cell, so software can poll status until it matches the state it asked for. The glitch-free gating cell itself is not part of the block.

In hardware mode, turn-off after the request drops can be held back by a hysteresis timer. The timer has its own enable and a length bit that picks a short delay (4 cycles) or a long delay (32 cycles). A rising request always turns the gate on and abandons any countdown in progress. A keep-on configuration input stops software from switching the gate off, so the gate is on whenever hardware does not own it.

Top module: `cg_owner_gate`

## Requirements
- R1: While and right after reset, clk_en_o and status_o are both 1 (software owner, enable set).
- R2: With owner_sw_i=1, clk_en_o after a clock edge equals sw_en_i | keep_on_i sampled at that edge.
- R3: With owner_sw_i=0 and hw_req_i=1 at an edge, clk_en_o is 1 after that edge.
- R4: With owner_sw_i=0, hyst_en_i=0 and hw_req_i=0 at an edge, clk_en_o is 0 after that edge.
- R5: With hysteresis enabled and hyst_long_i=0, after the first edge E that samples hw_req_i low, clk_en_o stays 1 until edge E+4 and is 0 after it.
- R6: With hysteresis enabled and hyst_long_i=1, the same hold lasts until edge E+32.
- R7: status_o equals the value clk_en_o had two clock cycles earlier.
- R8: keep_on_i=1 holds the gate on in software mode whatever sw_en_i is, and has no effect in hardware mode.
- R9: A request that rises during a hysteresis countdown keeps the gate on and cancels the count; the next drop starts a full new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| owner_sw_i | input | 1 | Gate owner: 0 hardware request, 1 software enable |
| sw_en_i | input | 1 | Software enable: 1 on, 0 off |
| keep_on_i | input | 1 | Forbid software turn-off |
| hyst_en_i | input | 1 | Enable turn-off hysteresis in hardware mode |
| hyst_long_i | input | 1 | Hysteresis length: 0 short, 1 long |
| hw_req_i | input | 1 | Hardware clock request |
| clk_en_o | output | 1 | Enable to the gating cell |
| status_o | output | 1 | Settled gate state for software polling |

## Verification
On every cycle the assertions check that software mode follows its enable and keep-on, that a hardware request forces the gate on, and that without hysteresis a dropped request turns it off. They also check that the gate holds while the hysteresis timer has not expired and that status trails the enable by two cycles. The exact length of each hysteresis window, cancellation of a countdown by a new request, and keep-on having no effect in hardware mode can only be shown by the bench. It sweeps every hysteresis setting, measures the on-time after each drop, and compares it with the delay it computes itself.

// File: rtl/cg_gate_pkg.sv
package cg_gate_pkg;

  typedef enum logic {
    OWNER_HW = 1'b0,
    OWNER_SW = 1'b1
  } owner_e;

  // Turn-off hold in cycles for a given hysteresis setting.
  function automatic int unsigned hold_cycles(logic en, logic long_sel,
                                              int unsigned short_c,
                                              int unsigned long_c);
    if (!en) return 0;
    return long_sel ? long_c : short_c;
  endfunction

endpackage

// File: rtl/cg_hyst_timer.sv
module cg_hyst_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expired_o = (cnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (step_i && !expired_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cg_status_lag.sv
module cg_status_lag #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[0] <= 1'b1;
          else         pipe_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) pipe_q[g] <= 1'b1;
          else         pipe_q[g] <= pipe_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cg_owner_gate.sv
module cg_owner_gate #(
  parameter int unsigned SHORT_DLY  = 4,
  parameter int unsigned LONG_DLY   = 32,
  parameter int unsigned STATUS_LAG = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic owner_sw_i,
  input  logic sw_en_i,
  input  logic keep_on_i,
  input  logic hyst_en_i,
  input  logic hyst_long_i,
  input  logic hw_req_i,
  output logic clk_en_o,
  output logic status_o
);
  import cg_gate_pkg::*;

  localparam int unsigned CNT_W = $clog2(LONG_DLY + 1);

  owner_e           owner;
  logic             gate_q;
  logic             gate_d;
  logic             hyst_clear;
  logic             hyst_step;
  logic             hyst_expired;
  logic [CNT_W-1:0] hyst_limit;

  assign owner      = owner_e'(owner_sw_i);
  assign hyst_limit = CNT_W'(hold_cycles(1'b1, hyst_long_i, SHORT_DLY, LONG_DLY));

  // Timer runs only while hardware owns an open gate with the request low.
  assign hyst_clear = (owner == OWNER_SW) || hw_req_i || !gate_q;
  assign hyst_step  = hyst_en_i;

  cg_hyst_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (hyst_clear),
    .step_i    (hyst_step),
    .limit_i   (hyst_limit),
    .expired_o (hyst_expired)
  );

  always_comb begin
    if (owner == OWNER_SW) begin
      gate_d = sw_en_i | keep_on_i;
    end else if (hw_req_i) begin
      gate_d = 1'b1;
    end else if (!gate_q) begin
      gate_d = 1'b0;
    end else if (!hyst_en_i) begin
      gate_d = 1'b0;
    end else begin
      gate_d = !hyst_expired;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate_d;
  end

  assign clk_en_o = gate_q;

  cg_status_lag #(.STAGES(STATUS_LAG)) u_status (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (gate_q),
    .q_o    (status_o)
  );
endmodule

// File: rtl/cg_owner_gate_chk.sv
module cg_owner_gate_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic owner_sw_i,
  input logic sw_en_i,
  input logic keep_on_i,
  input logic hyst_en_i,
  input logic hw_req_i,
  input logic hyst_expired,
  input logic clk_en_o,
  input logic status_o
);
  logic [1:0] since_rst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  a_r2_sw_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    owner_sw_i |=> (clk_en_o == $past(sw_en_i | keep_on_i)));

  a_r8_keep_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (owner_sw_i && keep_on_i) |=> clk_en_o);

  a_r3_req_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_sw_i && hw_req_i) |=> clk_en_o);

  a_r4_off_no_hyst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_sw_i && !hw_req_i && !hyst_en_i) |=> !clk_en_o);

  a_r5_hyst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!owner_sw_i && !hw_req_i && hyst_en_i && clk_en_o && !hyst_expired)
      |=> clk_en_o);

  a_r7_status_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst >= 2'd2) |-> (status_o == $past(clk_en_o, 2)));
endmodule

bind cg_owner_gate cg_owner_gate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .owner_sw_i   (owner_sw_i),
  .sw_en_i      (sw_en_i),
  .keep_on_i    (keep_on_i),
  .hyst_en_i    (hyst_en_i),
  .hw_req_i     (hw_req_i),
  .hyst_expired (hyst_expired),
  .clk_en_o     (clk_en_o),
  .status_o     (status_o)
);

// File: tb/cg_owner_gate_tb.sv
`timescale 1ns/1ps
module cg_owner_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic owner_sw = 1'b1, sw_en = 1'b1, keep_on = 1'b0;
  logic hyst_en = 1'b0, hyst_long = 1'b0, hw_req = 1'b0;
  logic clk_en, status;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  logic h1 = 1'b1, h2 = 1'b1;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  cg_owner_gate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .owner_sw_i(owner_sw), .sw_en_i(sw_en),
    .keep_on_i(keep_on), .hyst_en_i(hyst_en), .hyst_long_i(hyst_long),
    .hw_req_i(hw_req), .clk_en_o(clk_en), .status_o(status)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to the next falling edge; check R7 status lag there.
  task automatic tick();
    @(negedge clk);
    if (mon_on) check("R7 status lag", status, h2);
    h2 = h1;
    h1 = clk_en;
  endtask

  // Drop the request and count the cycles the gate stays on afterwards.
  task automatic measure_hold(output int held);
    hw_req = 1'b0;
    held = 0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (clk_en) held++;
      else break;
    end
  endtask

  initial begin
    int held;
    int expd;
    tick(); tick();
    check("R1 reset clk_en", clk_en, 1'b1);
    check("R1 reset status", status, 1'b1);
    rst_n = 1'b1;
    tick();
    check("R1 after reset clk_en", clk_en, 1'b1);
    check("R1 after reset status", status, 1'b1);
    h1 = clk_en; h2 = 1'b1;
    mon_on = 1'b1;

    // Software sweep over enable and keep-on
    for (int k = 0; k < 2; k++) begin
      for (int e = 0; e < 2; e++) begin
        owner_sw = 1'b1; keep_on = k[0]; sw_en = e[0];
        tick();
        check((k == 1) ? "R8 keep on sw mode" : "R2 sw follow", clk_en, e[0] | k[0]);
        tick(); tick();
        check("R7 status settled", status, e[0] | k[0]);
      end
    end

    // Hardware sweep over hysteresis settings and keep-on
    for (int k = 0; k < 2; k++) begin
      for (int he = 0; he < 2; he++) begin
        for (int hl = 0; hl < 2; hl++) begin
          owner_sw = 1'b0; keep_on = k[0]; sw_en = 1'b0;
          hyst_en = he[0]; hyst_long = hl[0];
          hw_req = 1'b1;
          tick();
          check("R3 request on", clk_en, 1'b1);
          tick();
          measure_hold(held);
          expd = (he == 0) ? 0 : ((hl == 1) ? 32 : 4);
          if (he == 0)      check_int(k == 1 ? "R8 keep no effect hw" : "R4 off no hyst", held, expd);
          else if (hl == 0) check_int("R5 short hold", held, expd);
          else              check_int("R6 long hold", held, expd);
          check("R4/R5/R6 finally off", clk_en, 1'b0);
          tick(); tick();
          check("R7 status off", status, 1'b0);
        end
      end
    end

    // Cancel a countdown with a new request
    keep_on = 1'b0; hyst_en = 1'b1; hyst_long = 1'b0;
    hw_req = 1'b1; tick();
    hw_req = 1'b0; tick(); tick(); tick();
    check("R9 still on mid count", clk_en, 1'b1);
    hw_req = 1'b1; tick();
    check("R9 request re-asserted", clk_en, 1'b1);
    tick(); tick(); tick(); tick(); tick();
    check("R9 held by request", clk_en, 1'b1);
    measure_hold(held);
    check_int("R9 full new delay", held, 4);

    // Switch from hardware off to software on
    owner_sw = 1'b1; sw_en = 1'b1; tick();
    check("R2 owner switch", clk_en, 1'b1);
    tick(); tick();

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule